// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the serial front end of a small byte-addressed nonvolatile memory, seen from an SPI host in mode 0. The host pulls chip select low, shifts in an 8-bit instruction and then, depending on the instruction, address and data bytes. Incoming bits are taken on the rising serial clock and outgoing bits change on the falling serial clock. The memory cells are modelled by a register array. A write takes effect only when chip select returns high, and it then starts a timed internal write cycle that the host can observe through the status byte.

All pins are brought into the system clock domain through synchronizers, and the serial clock and chip select edges are detected there. The serial clock must therefore be several times slower than the system clock. A write-protect pin can veto writes. A hold pin freezes the serial sequence in the middle of a transfer so that the host can resume it later from the same bit.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe` is 0. After reset the status byte reads 0x00 and every array byte reads 0xFF.
- R2: The first byte of each chip-select-low frame is the instruction. Bits are shifted MSB first. SI is taken on the rising SCK, and SO changes only after a falling SCK (or at frame start).
- R3: Instruction 0x06 sets the write-enable flag (status bit 1). Instruction 0x04 clears it.
- R4: Instruction 0x05 streams the status byte repeatedly for as long as chip select stays low. Bit 0 is busy, bit 1 is write-enable, and bits 7:2 are user bits.
- R5: Instruction 0000_a010 writes memory. The address byte follows, then data bytes, and the last complete data byte is written. The write commits only on chip select rising, and only if write-enable was set and no partial byte is pending. Otherwise nothing changes.
- R6: In instructions 0000_a011 and 0000_a010, bit 3 (a) is address bit 8 of the 9-bit address. The single address byte that follows gives bits 7:0.
- R7: Instruction 0000_a011 reads memory from the given address and streams bytes while chip select is low. The address increments after each byte and wraps from 0x1FF to 0x000.
- R8: A committed write holds status bit 0 at 1 for WR_CYCLES system clocks. At the end of the cycle the write-enable flag clears.
- R9: While busy, every instruction except 0x05 is ignored for the rest of its frame.
- R10: A low write-protect input at any time while chip select is low during a write frame cancels that write. Write-protect going low after the write cycle has started has no effect.
- R11: While the hold input is low, SCK edges are ignored, the bit position is frozen and `so_oe` is 0. After release, the sequence resumes from the same bit.
- R12: Instruction 0x01 followed by one data byte writes status bits 7:2 under the same commit rules as R5. Bits 1:0 of that byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |

## Verification
The bench targets several commit conditions. A write frame that ends three bits into a byte must leave the array untouched and show no busy. A design that commits on byte count alone would start a cycle there. A write frame sent while busy must not land in the array, and a design that decodes during busy would store it. A status write with write-protect dropped just before chip select rises must be cancelled, while write-protect dropped during the busy cycle must not cancel the write. A read starting at 0x1FF must wrap to 0x000, and an address with bit 8 supplied through the instruction must stay separate from its low-half alias. Finally, hold is asserted both in the middle of an address byte, with extra SCK pulses and garbage data, and in the middle of a read byte. A design that keeps counting during hold would store the data at a wrong address or return shifted read data.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [2:0] OP_RD_LO = 3'b011;
  localparam logic [2:0] OP_WR_LO = 3'b010;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_WDATA, PH_WSTAT, PH_OUT, PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic cs_n_s,
  output logic si_s,
  output logic hold_s,
  output logic wp_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise
);
  localparam int NB = 5;
  localparam logic [NB-1:0] IDLE_V = 5'b11100;

  logic [NB-1:0] raw;
  logic [NB-1:0] fin;
  logic [1:0]    prev_q;

  assign raw = {wp_n, hold_n, cs_n, si, sck};

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    logic [NB-1:0] q;
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_V;
        else        q <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_V;
        else        q <= g_st[k-1].q;
      end
    end
  end

  assign fin = g_st[STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b10;
    else        prev_q <= {fin[2], fin[0]};
  end

  assign sck_rise = fin[0] & ~prev_q[0];
  assign sck_fall = ~fin[0] & prev_q[0];
  assign cs_fall  = ~fin[2] & prev_q[1];
  assign cs_rise  = fin[2] & ~prev_q[1];
  assign si_s     = fin[1];
  assign cs_n_s   = fin[2];
  assign hold_s   = fin[3];
  assign wp_s     = fin[4];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          busy_q, busy_nx;
  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    busy_nx = busy_q;
    cnt_nx  = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_nx = 1'b0;
      else             cnt_nx  = cnt_q - 1'b1;
    end else if (start) begin
      busy_nx = 1'b1;
      cnt_nx  = CW'(CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_nx;
      cnt_q  <= cnt_nx;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_ee_pkg::*;
#(
  parameter int AW          = 9,
  parameter int WR_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam bit OPC_A8 = (AW == 9);
  localparam int ABYTES = (AW <= 9) ? 1 : (AW + 7) / 8;
  localparam int ABW    = $clog2(ABYTES + 1);

  logic cs_n_s, si_s, hold_s, wp_s, sck_rise, sck_fall, cs_fall, cs_rise;
  logic busy, wr_done, wr_start, mem_we;
  logic [7:0] rdata, byte_in, status_now;
  logic [AW-1:0] raddr, addr_shift;

  phase_t        phase_q, phase_nx;
  logic [2:0]    bitcnt_q, bitcnt_nx;
  logic [6:0]    sreg_q, sreg_nx;
  logic          is_rd_q, is_rd_nx;
  logic [ABW-1:0] abyte_q, abyte_nx;
  logic [AW-1:0] addr_q, addr_nx;
  logic [7:0]    out_byte_q, out_byte_nx;
  logic [2:0]    obit_q, obit_nx;
  logic          out_stat_q, out_stat_nx;
  logic          so_q, so_nx;
  logic          wel_q, wel_nx;
  logic [5:0]    ustat_q, ustat_nx;
  logic          pend_q, pend_nx;
  logic [7:0]    pend_data_q, pend_data_nx;
  logic          wp_bad_q, wp_bad_nx;

  spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .cs_n_s(cs_n_s), .si_s(si_s),
    .hold_s(hold_s), .wp_s(wp_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  spi_ee_array #(.AW(AW), .DW(8)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(addr_q),
    .wdata(pend_data_q), .raddr(raddr), .rdata(rdata)
  );

  spi_ee_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy), .done(wr_done)
  );

  assign byte_in    = {sreg_q, si_s};
  assign addr_shift = AW'({addr_q, byte_in});
  assign raddr      = (phase_q == PH_ADDR) ? addr_shift : addr_q;
  assign status_now = {ustat_q, wel_q, busy};

  always_comb begin
    phase_nx     = phase_q;
    bitcnt_nx    = bitcnt_q;
    sreg_nx      = sreg_q;
    is_rd_nx     = is_rd_q;
    abyte_nx     = abyte_q;
    addr_nx      = addr_q;
    out_byte_nx  = out_byte_q;
    obit_nx      = obit_q;
    out_stat_nx  = out_stat_q;
    so_nx        = so_q;
    wel_nx       = wel_q;
    ustat_nx     = ustat_q;
    pend_nx      = pend_q;
    pend_data_nx = pend_data_q;
    wp_bad_nx    = wp_bad_q;
    wr_start     = 1'b0;
    mem_we       = 1'b0;

    if (cs_fall) begin
      phase_nx  = PH_CMD;
      bitcnt_nx = '0;
      pend_nx   = 1'b0;
      wp_bad_nx = ~wp_s;
      so_nx     = 1'b0;
    end else if (cs_rise) begin
      if ((phase_q == PH_WDATA || phase_q == PH_WSTAT) && pend_q && wel_q &&
          !wp_bad_q && wp_s && bitcnt_q == '0 && !busy) begin
        wr_start = 1'b1;
        if (phase_q == PH_WDATA) mem_we   = 1'b1;
        else                     ustat_nx = pend_data_q[7:2];
      end
      phase_nx = PH_IDLE;
    end else if (!cs_n_s) begin
      if (!wp_s) wp_bad_nx = 1'b1;
      if (hold_s && sck_rise && phase_q != PH_IDLE) begin
        bitcnt_nx = bitcnt_q + 1'b1;
        sreg_nx   = byte_in[6:0];
        if (bitcnt_q == 3'd7) begin
          unique case (phase_q)
            PH_CMD: begin
              if (busy && byte_in != OP_RDSR) begin
                phase_nx = PH_SKIP;
              end else if (byte_in == OP_WREN) begin
                wel_nx = 1'b1;  phase_nx = PH_SKIP;
              end else if (byte_in == OP_WRDI) begin
                wel_nx = 1'b0;  phase_nx = PH_SKIP;
              end else if (byte_in == OP_RDSR) begin
                phase_nx = PH_OUT;  out_stat_nx = 1'b1;
                out_byte_nx = status_now;  obit_nx = 3'd7;
              end else if (byte_in == OP_WRSR) begin
                phase_nx = PH_WSTAT;
              end else if (byte_in[7:4] == 4'h0 && (OPC_A8 || !byte_in[3]) &&
                           (byte_in[2:0] == OP_RD_LO || byte_in[2:0] == OP_WR_LO)) begin
                phase_nx = PH_ADDR;
                is_rd_nx = (byte_in[2:0] == OP_RD_LO);
                abyte_nx = '0;
                addr_nx  = OPC_A8 ? AW'(byte_in[3]) : '0;
              end else begin
                phase_nx = PH_SKIP;
              end
            end
            PH_ADDR: begin
              abyte_nx = abyte_q + 1'b1;
              addr_nx  = addr_shift;
              if (abyte_q == ABW'(ABYTES - 1)) begin
                if (is_rd_q) begin
                  phase_nx = PH_OUT;  out_stat_nx = 1'b0;
                  out_byte_nx = rdata;  obit_nx = 3'd7;
                  addr_nx = addr_shift + 1'b1;
                end else begin
                  phase_nx = PH_WDATA;
                end
              end
            end
            PH_WDATA, PH_WSTAT: begin
              pend_nx      = 1'b1;
              pend_data_nx = byte_in;
            end
            default: ;
          endcase
        end
      end else if (hold_s && sck_fall && phase_q == PH_OUT) begin
        so_nx = out_byte_q[obit_q];
        if (obit_q == 3'd0) begin
          obit_nx = 3'd7;
          if (out_stat_q) begin
            out_byte_nx = status_now;
          end else begin
            out_byte_nx = rdata;
            addr_nx     = addr_q + 1'b1;
          end
        end else begin
          obit_nx = obit_q - 1'b1;
        end
      end
    end

    if (wr_done) wel_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      bitcnt_q    <= '0;
      sreg_q      <= '0;
      is_rd_q     <= 1'b0;
      abyte_q     <= '0;
      addr_q      <= '0;
      out_byte_q  <= '0;
      obit_q      <= 3'd7;
      out_stat_q  <= 1'b0;
      so_q        <= 1'b0;
      wel_q       <= 1'b0;
      ustat_q     <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      wp_bad_q    <= 1'b0;
    end else begin
      phase_q     <= phase_nx;
      bitcnt_q    <= bitcnt_nx;
      sreg_q      <= sreg_nx;
      is_rd_q     <= is_rd_nx;
      abyte_q     <= abyte_nx;
      addr_q      <= addr_nx;
      out_byte_q  <= out_byte_nx;
      obit_q      <= obit_nx;
      out_stat_q  <= out_stat_nx;
      so_q        <= so_nx;
      wel_q       <= wel_nx;
      ustat_q     <= ustat_nx;
      pend_q      <= pend_nx;
      pend_data_q <= pend_data_nx;
      wp_bad_q    <= wp_bad_nx;
    end
  end

  assign so    = so_q;
  assign so_oe = ~cs_n_s & hold_s;
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
  parameter int WR_CYCLES = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so,
  input logic       so_oe,
  input logic       busy,
  input logic       wel,
  input logic       sck_fall,
  input logic       cs_fall,
  input logic       hold_s,
  input logic [2:0] bitcnt
);
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  a_r2_so_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> ($past(sck_fall) || $past(cs_fall)));

  a_r3_wel_cleared_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  a_r5_start_with_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cs_n);

  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == WR_CYCLES));

  a_r11_hold_freezes_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !cs_fall) |=> $stable(bitcnt));
endmodule

bind spi_eeprom_slave spi_ee_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .so_oe(so_oe),
  .busy(busy), .wel(wel_q), .sck_fall(sck_fall), .cs_fall(cs_fall),
  .hold_s(hold_s), .bitcnt(bitcnt_q)
);

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int WRC  = 2000;
  localparam int HALF = 8;

  logic clk, rst_n, sck, cs_n, si, hold_n, wp_n;
  logic so, so_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  string      exp_tag_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  spi_eeprom_slave #(.AW(9), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pairs produced bytes with expected bytes
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        automatic logic [7:0] g = got_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = exp_tag_q.pop_front();
        check(g === e, t, g, e);
      end
    end
  end

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic r);
    si = b; wt(HALF); r = so; sck = 1; wt(HALF); sck = 0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      sbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_begin;
    cs_n = 0; wt(HALF);
  endtask

  task automatic cs_end;
    wt(HALF); cs_n = 1; wt(2 * HALF);
  endtask

  function automatic logic [7:0] mop(input bit rd, input logic [8:0] a);
    return {4'h0, a[8], rd ? 3'b011 : 3'b010};
  endfunction

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_begin; xbyte(op, r); cs_end;
  endtask

  task automatic rd_status(input string tag, input logic [7:0] e);
    logic [7:0] r;
    expect_byte(tag, e);
    cs_begin; xbyte(8'h05, r); xbyte(8'h00, r); got_q.push_back(r); cs_end;
  endtask

  task automatic rd_mem(input string tag, input logic [8:0] a, input logic [7:0] e);
    logic [7:0] r;
    expect_byte(tag, e);
    cs_begin; xbyte(mop(1, a), r); xbyte(a[7:0], r); xbyte(8'h00, r);
    got_q.push_back(r); cs_end;
  endtask

  task automatic wr_mem(input logic [8:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_begin; xbyte(mop(0, a), r); xbyte(a[7:0], r); xbyte(d, r); cs_end;
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] r;
    bit ok = 0;
    for (int k = 0; k < 60 && !ok; k++) begin
      cs_begin; xbyte(8'h05, r); xbyte(8'h00, r); cs_end;
      ok = (r[0] == 1'b0);
    end
    check(ok, tag, r, r & 8'hFE);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 0; sck = 0; cs_n = 1; si = 0; hold_n = 1; wp_n = 1;
    wt(10); rst_n = 1; wt(10);

    check(so_oe === 1'b0, "R1 so_oe after reset", so_oe, 0);
    rd_status("R1 R4 status after reset", 8'h00);
    rd_mem("R1 array erased", 9'h000, 8'hFF);

    cmd1(8'h06);
    rd_status("R3 wel set by 0x06", 8'h02);
    cmd1(8'h04);
    rd_status("R3 wel cleared by 0x04", 8'h00);

    wr_mem(9'h010, 8'h5A);
    rd_status("R5 no cycle without wel", 8'h00);
    rd_mem("R5 no write without wel", 9'h010, 8'hFF);

    cmd1(8'h06);
    wr_mem(9'h1A5, 8'h3C);
    rd_status("R8 busy after commit", 8'h03);
    wr_mem(9'h050, 8'h99);
    wait_ready("R8 cycle ends");
    rd_status("R8 wel cleared after cycle", 8'h00);
    rd_mem("R5 R6 data at high address", 9'h1A5, 8'h3C);
    rd_mem("R6 low alias untouched", 9'h0A5, 8'hFF);
    rd_mem("R9 write while busy ignored", 9'h050, 8'hFF);

    cmd1(8'h06);
    cs_begin; xbyte(mop(0, 9'h020), r); xbyte(8'h20, r);
    xbyte(8'h11, r); xbyte(8'h22, r); cs_end;
    wait_ready("R5 multi byte cycle");
    rd_mem("R5 last byte wins", 9'h020, 8'h22);

    cmd1(8'h06); wr_mem(9'h1FF, 8'h77); wait_ready("R7 setup a");
    cmd1(8'h06); wr_mem(9'h000, 8'h44); wait_ready("R7 setup b");
    expect_byte("R7 byte at 0x1FF", 8'h77);
    expect_byte("R7 wrap to 0x000", 8'h44);
    expect_byte("R7 then 0x001", 8'hFF);
    cs_begin; xbyte(mop(1, 9'h1FF), r); xbyte(8'hFF, r);
    xbyte(8'h00, r); got_q.push_back(r);
    xbyte(8'h00, r); got_q.push_back(r);
    xbyte(8'h00, r); got_q.push_back(r);
    cs_end;

    cmd1(8'h06);
    cs_begin; xbyte(mop(0, 9'h030), r); xbyte(8'h30, r); xbyte(8'hAB, r);
    for (int i = 0; i < 3; i++) begin logic b; sbit(1'b1, b); end
    cs_end;
    rd_status("R5 partial byte no cycle", 8'h02);
    rd_mem("R5 partial byte no write", 9'h030, 8'hFF);

    cs_begin; xbyte(8'h01, r); xbyte(8'h8C, r); wt(HALF); wp_n = 0; cs_end;
    rd_status("R10 wp drop cancels status write", 8'h02);
    wr_mem(9'h040, 8'h55);
    wp_n = 1;
    rd_mem("R10 wp low blocks memory write", 9'h040, 8'hFF);

    cs_begin; xbyte(8'h01, r); xbyte(8'h8F, r); cs_end;
    rd_status("R12 status write busy", 8'h8F);
    wait_ready("R12 cycle ends");
    rd_status("R12 user bits kept", 8'h8C);

    cmd1(8'h06);
    wr_mem(9'h060, 8'h66);
    wp_n = 0;
    wait_ready("R10 cycle with wp low");
    wp_n = 1;
    rd_mem("R10 wp after start no effect", 9'h060, 8'h66);

    cmd1(8'h06);
    cs_begin; xbyte(mop(0, 9'h070), r);
    for (int i = 7; i >= 4; i--) begin logic b; sbit(1'(8'h70 >> i), b); end
    hold_n = 0; wt(HALF);
    for (int i = 0; i < 5; i++) begin logic b; sbit(1'b1, b); end
    hold_n = 1; wt(HALF);
    for (int i = 3; i >= 0; i--) begin logic b; sbit(1'(8'h70 >> i), b); end
    xbyte(8'hC3, r); cs_end;
    wait_ready("R11 held write cycle");
    rd_mem("R11 held address resumed", 9'h070, 8'hC3);

    expect_byte("R11 read through hold", 8'hC3);
    cs_begin; xbyte(mop(1, 9'h070), r); xbyte(8'h70, r);
    for (int i = 7; i >= 5; i--) begin logic b; sbit(1'b0, b); r[i] = b; end
    hold_n = 0; wt(HALF);
    check(so_oe === 1'b0, "R11 so_oe off in hold", so_oe, 0);
    for (int i = 0; i < 4; i++) begin logic b; sbit(1'b0, b); end
    hold_n = 1; wt(HALF);
    check(so_oe === 1'b1, "R2 so_oe on in frame", so_oe, 1);
    for (int i = 4; i >= 0; i--) begin logic b; sbit(1'b0, b); r[i] = b; end
    got_q.push_back(r); cs_end;

    expect_byte("R4 status stream 1", 8'h8C);
    expect_byte("R4 status stream 2", 8'h8C);
    cs_begin; xbyte(8'h05, r);
    xbyte(8'h00, r); got_q.push_back(r);
    xbyte(8'h00, r); got_q.push_back(r);
    cs_end;

    wt(20);
    check(exp_q.size() == 0, "R2 all expected bytes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule